// File: doc/BRIEF.md
# Erase-Tolerant SEC-DED Codec for 64-Bit Words

This block protects 64-bit double words with eight check bits. Its encoder half takes a data word on its way into non-volatile storage and returns the check byte to store beside it. Its decoder half takes a stored word and its check byte on the way out. It returns the data with any single flipped bit repaired, raises one flag when it repaired something and another when it found two flipped bits it cannot repair, and exposes the raw syndrome so that test logic can compare it with an injected one.

The code is a Hamming code extended by an overall parity bit. The stored check byte is the plain code XORed with a fixed key, chosen so that a word of all ones with a check byte of all ones is a valid codeword. An erased array therefore reads back clean, and a blank check after an erase needs no special case. Each half has one register stage. The data width and the Hamming width are parameters, and the key is derived from them at elaboration.

Top module: `secded_codec`

## Requirements
- R1: The encoder output is registered: `enc_valid_o` is high in the cycle after `enc_valid_i` was high and low otherwise, and `enc_check_o` then holds the code for the data presented in that earlier cycle.
- R2: Data bit j sits at the j-th codeword position, counting from 3 upward and skipping every power of two. Check bits [HAM_W-1:0] are the XOR of the positions of all set data bits. Bit HAM_W makes the parity of data plus check bits even. The stored byte is this raw code XORed with the erase key. With the default widths the key is zero, so all-zero data encodes to 8'h00.
- R3: All-ones data encodes to an all-ones check field, and all-ones data with an all-ones check field decodes with no flag set.
- R4: A word stored without error decodes with both flags low, a zero syndrome and the data unchanged.
- R5: A single flipped data bit at position p gives `dec_sec_o`=1, `dec_ded_o`=0, syndrome {1, p} and the repaired data.
- R6: A single flipped check bit i < HAM_W gives syndrome {1, 1<<i}. A flipped bit HAM_W gives syndrome {1, 0}. In both cases `dec_sec_o`=1 and the data passes through unchanged.
- R7: Two flipped bits give `dec_ded_o`=1 and `dec_sec_o`=0, with the received data passed through uncorrected. The syndrome has its top bit at 0 and holds the XOR of the two single-bit syndromes.
- R8: The decoder has one cycle of latency: `dec_valid_o` follows `dec_valid_i` one cycle later. Both flags are low whenever `dec_valid_o` is low, and they are never high together.
- R9: Reset is synchronous and active high, and it clears both valid outputs, both flags, the syndrome and the data outputs.
- R10: With DATA_W=32 and HAM_W=6 the key is nonzero: all-zero data encodes to 7'h67, all-ones data encodes to 7'h7F, and single errors are repaired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid_i | input | 1 | Encode request |
| enc_data_i | input | DATA_W | Word to encode |
| enc_valid_o | output | 1 | Check field valid |
| enc_check_o | output | HAM_W+1 | Check field to store |
| dec_valid_i | input | 1 | Decode request |
| dec_data_i | input | DATA_W | Stored word read back |
| dec_check_i | input | HAM_W+1 | Stored check field read back |
| dec_valid_o | output | 1 | Decode result valid |
| dec_data_o | output | DATA_W | Repaired data |
| dec_sec_o | output | 1 | Single error repaired |
| dec_ded_o | output | 1 | Double error detected |
| dec_syndrome_o | output | HAM_W+1 | {parity mismatch, position syndrome} |

## Verification
The bench builds two instances. The first uses the default DATA_W=64 and HAM_W=7, where the erase key happens to be zero. On it the bench walks every single data-bit flip, every single check-bit flip and a spread of double flips over several data patterns. The second uses DATA_W=32 and HAM_W=6. There the key is nonzero, so the key XOR in both the encoder and the decoder is exercised and can be seen at the ports.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_SINGLE = 2'd1,
    ERR_DOUBLE = 2'd2
  } err_kind_e;

  // Codeword position of data bit j: positions from 3 upward, powers of two skipped.
  function automatic int data_pos(int j);
    int pos;
    int seen;
    pos  = 0;
    seen = -1;
    while (seen < j) begin
      pos++;
      if ((pos & (pos - 1)) != 0) seen++;
    end
    return pos;
  endfunction

  function automatic int bit_parity(int v);
    int p;
    p = 0;
    for (int b = 0; b < 32; b++) p ^= (v >> b) & 1;
    return p;
  endfunction

  // Key XORed into the raw code so that all-ones data maps to an all-ones check field.
  function automatic int erase_key(int data_w, int ham_w);
    int ham;
    int ovr;
    ham = 0;
    for (int j = 0; j < data_w; j++) ham ^= data_pos(j);
    ovr = (data_w % 2) ^ bit_parity(ham);
    return (((ovr ^ 1) & 1) << ham_w) | (ham ^ ((1 << ham_w) - 1));
  endfunction

endpackage

// File: rtl/secded_parity.sv
module secded_parity #(
  parameter int DATA_W = 64,
  parameter int HAM_W  = 7
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [HAM_W-1:0]  ham_o
);
  import secded_pkg::*;

  logic [DATA_W-1:0][HAM_W-1:0] contrib;

  generate
    for (genvar j = 0; j < DATA_W; j++) begin : g_pos
      localparam int POS = data_pos(j);
      assign contrib[j] = data_i[j] ? HAM_W'(POS) : '0;
    end
  endgenerate

  always_comb begin
    ham_o = '0;
    for (int j = 0; j < DATA_W; j++) ham_o ^= contrib[j];
  end

endmodule

// File: rtl/secded_enc.sv
module secded_enc #(
  parameter int DATA_W = 64,
  parameter int HAM_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [HAM_W:0]    check_o
);
  import secded_pkg::*;

  localparam int CHK_W = HAM_W + 1;
  localparam logic [CHK_W-1:0] KEY = CHK_W'(erase_key(DATA_W, HAM_W));

  logic [HAM_W-1:0] ham;
  logic [CHK_W-1:0] raw;

  secded_parity #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_par (
    .data_i(data_i),
    .ham_o (ham)
  );

  assign raw = {(^data_i) ^ (^ham), ham};

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      check_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) check_o <= raw ^ KEY;
    end
  end

  // R3: erased data must produce an erased check field
  a_r3_erased_encodes_ones: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (&data_i)) |=> (&check_o));

endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
  parameter int DATA_W = 64,
  parameter int HAM_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [HAM_W:0]    check_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              sec_o,
  output logic              ded_o,
  output logic [HAM_W:0]    syn_o
);
  import secded_pkg::*;

  localparam int CHK_W    = HAM_W + 1;
  localparam int LAST_POS = DATA_W + HAM_W;
  localparam logic [CHK_W-1:0] KEY = CHK_W'(erase_key(DATA_W, HAM_W));

  logic [CHK_W-1:0]  raw;
  logic [HAM_W-1:0]  calc;
  logic [HAM_W-1:0]  s_low;
  logic              pmis;
  err_kind_e         kind;
  logic [DATA_W-1:0] flip;

  secded_parity #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_par (
    .data_i(data_i),
    .ham_o (calc)
  );

  assign raw   = check_i ^ KEY;
  assign s_low = raw[HAM_W-1:0] ^ calc;
  assign pmis  = (^data_i) ^ (^raw);

  always_comb begin
    if (!pmis)
      kind = (s_low == '0) ? ERR_NONE : ERR_DOUBLE;
    else if (32'(s_low) <= 32'(LAST_POS))
      kind = ERR_SINGLE;
    else
      kind = ERR_DOUBLE;
  end

  generate
    for (genvar j = 0; j < DATA_W; j++) begin : g_fix
      localparam int POS = data_pos(j);
      assign flip[j] = (kind == ERR_SINGLE) && (s_low == HAM_W'(POS));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      sec_o   <= 1'b0;
      ded_o   <= 1'b0;
      syn_o   <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      sec_o   <= valid_i && (kind == ERR_SINGLE);
      ded_o   <= valid_i && (kind == ERR_DOUBLE);
      if (valid_i) begin
        data_o <= data_i ^ flip;
        syn_o  <= {pmis, s_low};
      end
    end
  end

  // R4: a zero syndrome on a valid result never raises a flag
  a_r4_clean_no_flags: assert property (@(posedge clk) disable iff (rst)
    (valid_o && (syn_o == '0)) |-> (!sec_o && !ded_o));

  // R5: a repaired error always carries an odd parity mismatch
  a_r5_sec_odd_parity: assert property (@(posedge clk) disable iff (rst)
    sec_o |-> syn_o[HAM_W]);

  // R7: even parity with a nonzero position syndrome is a double error
  a_r7_even_nonzero_ded: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !syn_o[HAM_W] && (syn_o[HAM_W-1:0] != '0)) |-> ded_o);

  // R6: an error in the check field leaves the data untouched
  a_r6_check_err_keeps_data: assert property (@(posedge clk) disable iff (rst)
    (sec_o && $onehot0(syn_o[HAM_W-1:0])) |-> (data_o == $past(data_i)));

endmodule

// File: rtl/secded_codec.sv
module secded_codec #(
  parameter int DATA_W = 64,
  parameter int HAM_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_valid_i,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic              enc_valid_o,
  output logic [HAM_W:0]    enc_check_o,
  input  logic              dec_valid_i,
  input  logic [DATA_W-1:0] dec_data_i,
  input  logic [HAM_W:0]    dec_check_i,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic              dec_sec_o,
  output logic              dec_ded_o,
  output logic [HAM_W:0]    dec_syndrome_o
);

  secded_enc #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_enc (
    .clk    (clk),
    .rst    (rst),
    .valid_i(enc_valid_i),
    .data_i (enc_data_i),
    .valid_o(enc_valid_o),
    .check_o(enc_check_o)
  );

  secded_dec #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_dec (
    .clk    (clk),
    .rst    (rst),
    .valid_i(dec_valid_i),
    .data_i (dec_data_i),
    .check_i(dec_check_i),
    .valid_o(dec_valid_o),
    .data_o (dec_data_o),
    .sec_o  (dec_sec_o),
    .ded_o  (dec_ded_o),
    .syn_o  (dec_syndrome_o)
  );

  // R1: encoder latency of one cycle
  a_r1_enc_latency: assert property (@(posedge clk) disable iff (rst)
    enc_valid_i |=> enc_valid_o);

  // R8: decoder latency and idle behaviour
  a_r8_dec_latency: assert property (@(posedge clk) disable iff (rst)
    dec_valid_i |=> dec_valid_o);
  a_r8_dec_idle: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_i |=> !dec_valid_o);
  a_r8_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_o |-> (!dec_sec_o && !dec_ded_o));
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(dec_sec_o && dec_ded_o));

endmodule

// File: tb/sim_secded_codec.sv
`timescale 1ns/1ps
module sim_secded_codec;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;

  // default instance
  logic        enc_valid_i = 1'b0;
  logic [63:0] enc_data_i  = '0;
  logic        enc_valid_o;
  logic [7:0]  enc_check_o;
  logic        dec_valid_i = 1'b0;
  logic [63:0] dec_data_i  = '0;
  logic [7:0]  dec_check_i = '0;
  logic        dec_valid_o;
  logic [63:0] dec_data_o;
  logic        dec_sec_o, dec_ded_o;
  logic [7:0]  dec_syndrome_o;

  secded_codec u0 (
    .clk(clk), .rst(rst),
    .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
    .enc_valid_o(enc_valid_o), .enc_check_o(enc_check_o),
    .dec_valid_i(dec_valid_i), .dec_data_i(dec_data_i), .dec_check_i(dec_check_i),
    .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
    .dec_sec_o(dec_sec_o), .dec_ded_o(dec_ded_o), .dec_syndrome_o(dec_syndrome_o)
  );

  // narrow instance with a nonzero erase key
  logic        b_enc_valid_i = 1'b0;
  logic [31:0] b_enc_data_i  = '0;
  logic        b_enc_valid_o;
  logic [6:0]  b_enc_check_o;
  logic        b_dec_valid_i = 1'b0;
  logic [31:0] b_dec_data_i  = '0;
  logic [6:0]  b_dec_check_i = '0;
  logic        b_dec_valid_o;
  logic [31:0] b_dec_data_o;
  logic        b_dec_sec_o, b_dec_ded_o;
  logic [6:0]  b_dec_syndrome_o;

  secded_codec #(.DATA_W(32), .HAM_W(6)) u1 (
    .clk(clk), .rst(rst),
    .enc_valid_i(b_enc_valid_i), .enc_data_i(b_enc_data_i),
    .enc_valid_o(b_enc_valid_o), .enc_check_o(b_enc_check_o),
    .dec_valid_i(b_dec_valid_i), .dec_data_i(b_dec_data_i), .dec_check_i(b_dec_check_i),
    .dec_valid_o(b_dec_valid_o), .dec_data_o(b_dec_data_o),
    .dec_sec_o(b_dec_sec_o), .dec_ded_o(b_dec_ded_o), .dec_syndrome_o(b_dec_syndrome_o)
  );

  typedef struct {
    logic [63:0] data;
    logic        sec;
    logic        ded;
    logic [7:0]  syn;
    string       req;
  } exp_t;

  exp_t sb[$];

  function automatic int ref_pos(int j);
    int cnt;
    cnt = -1;
    for (int p = 1; p < 128; p++) begin
      if ((p & (p - 1)) != 0) begin
        cnt++;
        if (cnt == j) return p;
      end
    end
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic encode(input logic [63:0] d, output logic [7:0] c);
    @(negedge clk);
    enc_valid_i = 1'b1;
    enc_data_i  = d;
    @(negedge clk);
    enc_valid_i = 1'b0;
    c = enc_check_o;
    check(enc_valid_o == 1'b1, "R1", "enc_valid_o after request", 128'(enc_valid_o), 128'(1));
  endtask

  task automatic dsend(input logic [63:0] d, input logic [7:0] c, input exp_t e);
    @(negedge clk);
    dec_valid_i = 1'b1;
    dec_data_i  = d;
    dec_check_i = c;
    sb.push_back(e);
    @(negedge clk);
    dec_valid_i = 1'b0;
  endtask

  // monitor: compares each decode result against the queued expectation
  always @(negedge clk) begin
    if (!rst && dec_valid_o) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8", "result without request", 128'(dec_valid_o), 128'(0));
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(dec_data_o == e.data && dec_sec_o == e.sec && dec_ded_o == e.ded &&
              dec_syndrome_o == e.syn, e.req, "decode {sec,ded,syn,data}",
              {54'(0), dec_sec_o, dec_ded_o, dec_syndrome_o, dec_data_o},
              {54'(0), e.sec, e.ded, e.syn, e.data});
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  logic [63:0] pats [5] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hA5A5_5A5A_0F0F_F0F0,
                            64'h0123_4567_89AB_CDEF, 64'hDEAD_BEEF_CAFE_F00D};

  initial begin : main
    logic [7:0] c;
    logic [7:0] ex;
    exp_t e;
    int pa, pb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check(!enc_valid_o && !dec_valid_o && !dec_sec_o && !dec_ded_o && dec_syndrome_o == 0 &&
          enc_check_o == 0 && dec_data_o == 0, "R9", "outputs in reset",
          {enc_valid_o, dec_valid_o, dec_sec_o, dec_ded_o, dec_syndrome_o}, 128'(0));
    rst = 1'b0;

    // R3: erased word
    encode(64'hFFFF_FFFF_FFFF_FFFF, c);
    check(c == 8'hFF, "R3", "check of all-ones data", 128'(c), 128'(8'hFF));
    e = '{64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 8'h00, "R3"};
    dsend(64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, e);

    // R2: all-zero data and single set bits
    encode(64'h0, c);
    check(c == 8'h00, "R2", "check of zero data", 128'(c), 128'(0));
    foreach (pats[k]) begin end
    for (int j = 0; j < 64; j += 9) begin
      encode(64'h1 << j, c);
      pa = ref_pos(j);
      ex = {1'b1 ^ (^pa[6:0]), pa[6:0]};
      check(c == ex, "R2", "check of one-hot data", 128'(c), 128'(ex));
    end

    // R1: encoder valid drops when idle
    @(negedge clk);
    check(enc_valid_o == 1'b0, "R1", "enc_valid_o when idle", 128'(enc_valid_o), 128'(0));

    for (int k = 0; k < 5; k++) begin
      logic [63:0] d;
      d = pats[k];
      encode(d, c);
      // R4: clean decode
      e = '{d, 1'b0, 1'b0, 8'h00, "R4"};
      dsend(d, c, e);
      if (k == 2 || k == 3) begin
        // R5: every single data-bit error
        for (int j = 0; j < 64; j++) begin
          pa = ref_pos(j);
          e = '{d, 1'b1, 1'b0, {1'b1, pa[6:0]}, "R5"};
          dsend(d ^ (64'h1 << j), c, e);
        end
      end
      // R6: every single check-bit error
      for (int i = 0; i < 8; i++) begin
        ex = (i < 7) ? (8'h80 | (8'h1 << i)) : 8'h80;
        e = '{d, 1'b1, 1'b0, ex, "R6"};
        dsend(d, c ^ (8'h1 << i), e);
      end
      // R7: double errors, data-data, data-check and check-check
      for (int j = 0; j < 60; j += 13) begin
        pa = ref_pos(j);
        pb = ref_pos(j + 3);
        e = '{d ^ (64'h9 << j), 1'b0, 1'b1, {1'b0, pa[6:0] ^ pb[6:0]}, "R7"};
        dsend(d ^ (64'h9 << j), c, e);
        e = '{d ^ (64'h1 << j), 1'b0, 1'b1, {1'b0, pa[6:0] ^ 7'h04}, "R7"};
        dsend(d ^ (64'h1 << j), c ^ 8'h04, e);
      end
      e = '{d, 1'b0, 1'b1, 8'h03, "R7"};
      dsend(d, c ^ 8'h03, e);
    end

    // R8: idle decoder shows no flags
    @(negedge clk);
    check(!dec_valid_o && !dec_sec_o && !dec_ded_o, "R8", "idle decoder flags",
          {dec_valid_o, dec_sec_o, dec_ded_o}, 128'(0));
    check(sb.size() == 0, "R8", "results outstanding", 128'(sb.size()), 128'(0));

    // R9: synchronous reset during a request
    @(negedge clk);
    dec_valid_i = 1'b1;
    dec_data_i  = 64'h1;
    dec_check_i = 8'h00;
    enc_valid_i = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check(!dec_valid_o && !dec_sec_o && !dec_ded_o && !enc_valid_o, "R9",
          "outputs after reset with request", {dec_valid_o, dec_sec_o, dec_ded_o, enc_valid_o}, 128'(0));
    dec_valid_i = 1'b0;
    enc_valid_i = 1'b0;
    rst = 1'b0;

    // R10: narrow instance with nonzero key
    @(negedge clk);
    b_enc_valid_i = 1'b1;
    b_enc_data_i  = 32'h0;
    @(negedge clk);
    check(b_enc_check_o == 7'h67, "R10", "narrow check of zero data", 128'(b_enc_check_o), 128'(7'h67));
    b_enc_data_i = 32'hFFFF_FFFF;
    @(negedge clk);
    b_enc_valid_i = 1'b0;
    check(b_enc_check_o == 7'h7F, "R10", "narrow check of all-ones data", 128'(b_enc_check_o), 128'(7'h7F));
    b_dec_valid_i = 1'b1;
    b_dec_data_i  = 32'h0;
    b_dec_check_i = 7'h67;
    @(negedge clk);
    check(b_dec_valid_o && !b_dec_sec_o && !b_dec_ded_o && b_dec_data_o == 0 && b_dec_syndrome_o == 0,
          "R10", "narrow clean decode", {b_dec_sec_o, b_dec_ded_o, b_dec_syndrome_o}, 128'(0));
    b_dec_data_i = 32'h0000_0020;
    pa = ref_pos(5);
    @(negedge clk);
    check(b_dec_sec_o && !b_dec_ded_o && b_dec_data_o == 0 && b_dec_syndrome_o == {1'b1, pa[5:0]},
          "R10", "narrow single repair", {b_dec_sec_o, b_dec_ded_o, b_dec_syndrome_o, b_dec_data_o},
          {1'b1, 1'b0, 1'b1, pa[5:0], 32'h0});
    b_dec_data_i  = 32'hFFFF_FFFF;
    b_dec_check_i = 7'h7F;
    @(negedge clk);
    b_dec_valid_i = 1'b0;
    check(!b_dec_sec_o && !b_dec_ded_o && b_dec_data_o == 32'hFFFF_FFFF, "R10",
          "narrow erased decode", {b_dec_sec_o, b_dec_ded_o, b_dec_data_o}, {2'b00, 32'hFFFF_FFFF});

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule